// File: doc/BRIEF.md
# Configuration Load Mode Sequencer

This block brings up the configuration of a device after every reset. The load always runs in two steps. First, a block of core configuration words is fetched. Then a block of hardware and firmware configuration words is fetched from one of three controllers: an internal ROM, an external EEPROM or a host bus. Two mode pins choose that controller. They are sampled on the first clock after reset is released.

Each step reads a programmable number of words. The reads start at word address 0 and go through one request/response source interface, with one word outstanding at a time. Each word that arrives is written into a configuration memory port, tagged with the step it belongs to. Each step has a two-bit status that shows its progress.

A failed step stops the sequence, and only a reset clears it. The failure can be a source error or a response that never arrives. The reserved pin code stops the load before it starts. Once the load has completed, the host may move the mode pins to hand control to another loader controller. The same move is ignored while a load is in progress.

Top module: `cfg_load_seq`

## Requirements
- R1: The mode pins are sampled on the first clock edge after `rst_n` is released, and the chosen controller is reported on `active_ctl` with the same code: 2'b00 internal ROM, 2'b01 host bus, 2'b10 external EEPROM.
- R2: The core step (`src_stage`=0) always runs to completion before the hardware/firmware step (`src_stage`=1) issues its first request. The hardware/firmware status never leaves idle unless the core status is done.
- R3: `core_status` and `load_status` use the code 2'b00 idle, 2'b01 loading, 2'b10 done, 2'b11 failed. Both are idle during reset. The core status reads loading right after the first clock edge following reset release.
- R4: A step with word count N reads addresses 0 to N-1 in increasing order. It writes every received word to the configuration port with the same address and the step tag. It becomes done in the cycle of its last write. A count of 0 completes the step without any request.
- R5: A source error during a step marks that step failed and stops all further requests. After a core failure the hardware/firmware status stays idle.
- R6: A step that waits TIMEOUT_CYC (default 1024) consecutive request cycles without a data-valid response is marked failed.
- R7: A failed status and a done status hold until the next reset, and no load is retried without one. A reset starts a complete new load.
- R8: The reserved pin code 2'b11, when sampled after reset, sets `mode_err`, which holds until reset. No request is made and both statuses stay idle.
- R9: After the whole load is done, a change of the mode pins to a non-reserved code moves `active_ctl` to that code on the next clock edge without any new load. The reserved code is ignored there.
- R10: Mode pin changes while either step is loading have no effect on `active_ctl` or `mode_err`, and the load completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 2 | Loader controller select (00 ROM, 01 bus, 10 EEPROM, 11 reserved) |
| core_words | input | ADDR_W+1 | Word count of the core step |
| hwfw_words | input | ADDR_W+1 | Word count of the hardware/firmware step |
| src_req | output | 1 | Word read request, held until valid or error |
| src_stage | output | 1 | Step being served: 0 core, 1 hardware/firmware |
| src_addr | output | ADDR_W | Word address of the request |
| src_rdata | input | DATA_W | Returned word |
| src_valid | input | 1 | Returned word is valid this cycle |
| src_err | input | 1 | Source reports an error this cycle |
| cfg_we | output | 1 | Configuration memory write enable |
| cfg_stage | output | 1 | Step tag of the write |
| cfg_waddr | output | ADDR_W | Configuration memory write address |
| cfg_wdata | output | DATA_W | Configuration memory write data |
| core_status | output | 2 | Core step status |
| load_status | output | 2 | Hardware/firmware step status |
| active_ctl | output | 2 | Active loader controller code |
| mode_err | output | 1 | Reserved mode code was sampled |

## Verification
Several rules are checked on every clock by the assertions:
- The hardware/firmware status never moves while the core step is unfinished.
- Failed and done statuses never change.
- The active controller is frozen during loading.
- No request follows a mode error.
- The address and the wait timer stay inside their bounds.

Other behaviour needs the bench's scenarios. These are the exact order and content of the written words, the zero-length step, the cycle in which the timeout fires, the outcome of an error on a given word, the restart after reset, and the switch of controller after completion.

// File: rtl/cfg_load_pkg.sv
// Shared types of the configuration load sequencer.
// Assumes: two load steps, two-bit status and mode codes.
package cfg_load_pkg;

    localparam int NUM_STEPS = 2;

    typedef enum logic [1:0] {
        STEP_IDLE    = 2'b00,
        STEP_LOADING = 2'b01,
        STEP_DONE    = 2'b10,
        STEP_FAILED  = 2'b11
    } step_stat_e;

    typedef enum logic [1:0] {
        CTL_ROM      = 2'b00,
        CTL_BUS      = 2'b01,
        CTL_EEPROM   = 2'b10,
        CTL_RESERVED = 2'b11
    } ctl_code_e;

    typedef enum logic [2:0] {
        SQ_START,
        SQ_CORE,
        SQ_HWFW,
        SQ_COMPLETE,
        SQ_FAILED,
        SQ_HALTED
    } seq_state_e;

endpackage

// File: rtl/cfg_mode_ctl.sv
// Mode pin handling: captures the loader controller code once after reset,
// flags the reserved code, and follows run-time pin changes only while the
// owner allows it. Assumes the pins are stable relative to clk.
module cfg_mode_ctl
    import cfg_load_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_pins,
    input  logic       sample,
    input  logic       allow_switch,
    output logic       pins_ok,
    output logic [1:0] active_ctl,
    output logic       mode_err
);

    // Pin code usable as a loader controller
    assign pins_ok = (mode_pins != CTL_RESERVED);

    // Capture at start-up, follow later only when allowed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_ctl <= CTL_ROM;
            mode_err   <= 1'b0;
        end else if (sample) begin
            if (pins_ok) active_ctl <= mode_pins;
            else         mode_err   <= 1'b1;
        end else if (allow_switch && pins_ok) begin
            active_ctl <= mode_pins;
        end
    end

    AST_MODE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err); // R8

    AST_ACTIVE_NEVER_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        active_ctl != CTL_RESERVED); // R9

endmodule

// File: rtl/cfg_word_loader.sv
// Word loader for one step at a time: on start it reads words 0..N-1, one
// outstanding request, and reports done on the last valid word or fail on
// a source error or a response timeout. Assumes start only while idle or in
// the cycle its previous step completes.
module cfg_word_loader #(
    parameter int ADDR_W      = 10,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   word_cnt,
    input  logic              src_valid,
    input  logic              src_err,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              fail
);

    localparam int CNT_W = ADDR_W + 1;
    localparam int TMR_W = $clog2(TIMEOUT_CYC) + 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_r;
    logic [TMR_W-1:0] tmr;
    logic             empty_r;
    logic             last_word;
    logic             tmr_exp;

    // Current word is the final one of the step
    assign last_word = ({1'b0, addr} == (cnt_r - CNT_W'(1)));
    // Wait budget used up
    assign tmr_exp   = (tmr == TMR_LAST);

    // Step end indications, taken by the sequencer in the same cycle
    assign done = (busy && src_valid && !src_err && last_word) || empty_r;
    assign fail = busy && (src_err || (!src_valid && tmr_exp));

    // Address walk, wait timer and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            addr    <= '0;
            cnt_r   <= '0;
            tmr     <= '0;
            empty_r <= 1'b0;
        end else begin
            empty_r <= 1'b0;
            if (start) begin
                addr  <= '0;
                tmr   <= '0;
                cnt_r <= word_cnt;
                if (word_cnt == '0) begin
                    busy    <= 1'b0;
                    empty_r <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                if (src_err) begin
                    busy <= 1'b0;
                end else if (src_valid) begin
                    tmr <= '0;
                    if (last_word) busy <= 1'b0;
                    else           addr <= addr + 1'b1;
                end else if (tmr_exp) begin
                    busy <= 1'b0;
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, addr} < cnt_r)); // R4

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tmr <= TMR_LAST)); // R6

    AST_STOP_AFTER_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_err && !start) |=> !busy); // R5

endmodule

// File: rtl/cfg_step_status.sv
// Status register of one load step: idle -> loading -> done or failed.
// Done and failed are final until reset. Assumes start, done and fail are
// single-cycle strobes from the sequencer.
module cfg_step_status
    import cfg_load_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       done,
    input  logic       fail,
    output step_stat_e status
);

    // Progress of the step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= STEP_IDLE;
        end else begin
            case (status)
                STEP_IDLE:    if (start) status <= STEP_LOADING;
                STEP_LOADING: begin
                    if (fail)      status <= STEP_FAILED;
                    else if (done) status <= STEP_DONE;
                end
                default:      status <= status;
            endcase
        end
    end

    AST_FAILED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STEP_FAILED) |=> (status == STEP_FAILED)); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STEP_DONE) |=> (status == STEP_DONE)); // R7

endmodule

// File: rtl/cfg_load_seq.sv
// Configuration load sequencer top: samples the mode pins after reset, runs
// the core step then the hardware/firmware step through one word loader,
// writes each word to the configuration port and keeps a status per step.
// Assumes one outstanding source request and a source that answers with a
// one-cycle valid or error strobe.
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 10,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_pins,
    input  logic [ADDR_W:0]   core_words,
    input  logic [ADDR_W:0]   hwfw_words,
    output logic              src_req,
    output logic              src_stage,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_rdata,
    input  logic              src_valid,
    input  logic              src_err,
    output logic              cfg_we,
    output logic              cfg_stage,
    output logic [ADDR_W-1:0] cfg_waddr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic [1:0]        core_status,
    output logic [1:0]        load_status,
    output logic [1:0]        active_ctl,
    output logic              mode_err
);

    localparam int STEP_CORE = 0;
    localparam int STEP_HWFW = 1;

    seq_state_e        state, nxt_state;
    logic              pins_ok;
    logic              sample;
    logic              ld_start;
    logic [ADDR_W:0]   ld_cnt;
    logic              ld_busy;
    logic [ADDR_W-1:0] ld_addr;
    logic              ld_done;
    logic              ld_fail;
    logic [NUM_STEPS-1:0] st_start;
    logic [NUM_STEPS-1:0] st_done;
    logic [NUM_STEPS-1:0] st_fail;
    step_stat_e        st_val [NUM_STEPS];

    cfg_mode_ctl u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_pins    (mode_pins),
        .sample       (sample),
        .allow_switch (state == SQ_COMPLETE),
        .pins_ok      (pins_ok),
        .active_ctl   (active_ctl),
        .mode_err     (mode_err)
    );

    cfg_word_loader #(
        .ADDR_W      (ADDR_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ld_start),
        .word_cnt  (ld_cnt),
        .src_valid (src_valid),
        .src_err   (src_err),
        .busy      (ld_busy),
        .addr      (ld_addr),
        .done      (ld_done),
        .fail      (ld_fail)
    );

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
        cfg_step_status u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (st_start[g]),
            .done   (st_done[g]),
            .fail   (st_fail[g]),
            .status (st_val[g])
        );
    end

    // Sequence decisions: which step starts, ends or fails this cycle
    always_comb begin
        nxt_state = state;
        sample    = 1'b0;
        ld_start  = 1'b0;
        ld_cnt    = core_words;
        st_start  = '0;
        st_done   = '0;
        st_fail   = '0;
        case (state)
            SQ_START: begin
                sample = 1'b1;
                if (pins_ok) begin
                    ld_start            = 1'b1;
                    st_start[STEP_CORE] = 1'b1;
                    nxt_state           = SQ_CORE;
                end else begin
                    nxt_state = SQ_HALTED;
                end
            end
            SQ_CORE: begin
                if (ld_fail) begin
                    st_fail[STEP_CORE] = 1'b1;
                    nxt_state          = SQ_FAILED;
                end else if (ld_done) begin
                    st_done[STEP_CORE]  = 1'b1;
                    st_start[STEP_HWFW] = 1'b1;
                    ld_start            = 1'b1;
                    ld_cnt              = hwfw_words;
                    nxt_state           = SQ_HWFW;
                end
            end
            SQ_HWFW: begin
                if (ld_fail) begin
                    st_fail[STEP_HWFW] = 1'b1;
                    nxt_state          = SQ_FAILED;
                end else if (ld_done) begin
                    st_done[STEP_HWFW] = 1'b1;
                    nxt_state          = SQ_COMPLETE;
                end
            end
            default: nxt_state = state;
        endcase
    end

    // Sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_START;
        else        state <= nxt_state;
    end

    // Source request and configuration write port
    assign src_req     = ld_busy;
    assign src_stage   = (state == SQ_HWFW);
    assign src_addr    = ld_addr;
    assign cfg_we      = ld_busy && src_valid && !src_err;
    assign cfg_stage   = src_stage;
    assign cfg_waddr   = ld_addr;
    assign cfg_wdata   = src_rdata;
    assign core_status = st_val[STEP_CORE];
    assign load_status = st_val[STEP_HWFW];

    AST_CORE_BEFORE_HWFW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_status != STEP_IDLE) |-> (core_status == STEP_DONE)); // R2

    AST_NO_REQ_ON_MODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!src_req && core_status == STEP_IDLE)); // R8

    AST_CTL_FROZEN_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_CORE || state == SQ_HWFW) |=> $stable(active_ctl)); // R10

    AST_NO_REQ_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (core_status == STEP_FAILED || load_status == STEP_FAILED) |-> !src_req); // R5

endmodule

// File: tb/test_cfg_load_seq.sv
// Directed bench: one task per scenario, a handshake source model and a
// write monitor that checks address order and data of every written word.
module test_cfg_load_seq;

    localparam int CLK_P  = 10;
    localparam int DW     = 16;
    localparam int AW     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_pins = 2'b00;
    logic [AW:0]   core_words = '0;
    logic [AW:0]   hwfw_words = '0;
    logic          src_req, src_stage, cfg_we, cfg_stage, mode_err;
    logic [AW-1:0] src_addr, cfg_waddr;
    logic [DW-1:0] src_rdata = '0, cfg_wdata;
    logic          src_valid = 1'b0, src_err = 1'b0;
    logic [1:0]    core_status, load_status, active_ctl;

    int checks = 0;
    int errors = 0;

    // Source model settings
    int lat = 0;
    int silent_step = -1;
    int err_step = -1;
    int err_addr = -1;
    int wcnt = 0;

    // Write monitor results
    int wr_cnt [2];
    int wr_bad = 0;
    int req_seen = 0;

    cfg_load_seq #(.DATA_W(DW), .ADDR_W(AW), .TIMEOUT_CYC(1024)) i_cfg_load_seq (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .core_words(core_words), .hwfw_words(hwfw_words),
        .src_req(src_req), .src_stage(src_stage), .src_addr(src_addr),
        .src_rdata(src_rdata), .src_valid(src_valid), .src_err(src_err),
        .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .core_status(core_status),
        .load_status(load_status), .active_ctl(active_ctl), .mode_err(mode_err)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [DW-1:0] word_of(input int step, input int a);
        return {(step != 0) ? 6'h2A : 6'h15, a[AW-1:0]};
    endfunction

    // Source model: answers requests at the falling edge
    always @(negedge clk) begin
        src_valid = 1'b0;
        src_err   = 1'b0;
        if (rst_n && src_req) begin
            if (silent_step == int'(src_stage)) begin
                wcnt = 0;
            end else if (err_step == int'(src_stage) && err_addr == int'(src_addr)) begin
                src_err = 1'b1;
            end else if (wcnt >= lat) begin
                src_valid = 1'b1;
                src_rdata = word_of(int'(src_stage), int'(src_addr));
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    // Write monitor: checks each write a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n && src_req) req_seen++;
        if (rst_n && cfg_we) begin
            if (int'(cfg_waddr) != wr_cnt[cfg_stage] ||
                cfg_wdata != word_of(int'(cfg_stage), int'(cfg_waddr)))
                wr_bad++;
            if (cfg_stage && wr_cnt[0] != int'(core_words)) wr_bad++;
            wr_cnt[cfg_stage]++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] pins, input int nc, input int nh);
        @(negedge clk);
        rst_n = 1'b0;
        mode_pins = pins;
        core_words = (AW+1)'(nc);
        hwfw_words = (AW+1)'(nh);
        repeat (3) @(negedge clk);
        wr_cnt[0] = 0; wr_cnt[1] = 0; wr_bad = 0; req_seen = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_end(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (load_status[1] || core_status == 2'b11) break;
        end
        #(CLK_P/4 + 1);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(core_status == 2'b00, "R3 core idle in reset", core_status, 0);
        chk(load_status == 2'b00, "R3 load idle in reset", load_status, 0);
        chk(!src_req && !mode_err, "R3 no request in reset", src_req, 0);
    endtask

    task automatic t_rom_load;
        lat = 0; silent_step = -1; err_step = -1;
        do_reset(2'b00, 5, 7);
        @(negedge clk); #1;
        chk(core_status == 2'b01, "R3 core loading after first edge", core_status, 1);
        chk(load_status == 2'b00, "R2 hwfw idle while core loads", load_status, 0);
        wait_end(200);
        chk(core_status == 2'b10, "R3 core done", core_status, 2);
        chk(load_status == 2'b10, "R3 hwfw done", load_status, 2);
        chk(wr_cnt[0] == 5, "R4 core word count", wr_cnt[0], 5);
        chk(wr_cnt[1] == 7, "R4 hwfw word count", wr_cnt[1], 7);
        chk(wr_bad == 0, "R2 R4 write order and data", wr_bad, 0);
        chk(active_ctl == 2'b00, "R1 ROM controller", active_ctl, 0);
        repeat (10) @(negedge clk); #1;
        chk(load_status == 2'b10 && !src_req, "R7 done holds without reload", load_status, 2);
    endtask

    task automatic t_eeprom_slow;
        lat = 3; silent_step = -1; err_step = -1;
        do_reset(2'b10, 4, 9);
        wait_end(400);
        chk(active_ctl == 2'b10, "R1 EEPROM controller", active_ctl, 2);
        chk(load_status == 2'b10, "R4 hwfw done with slow source", load_status, 2);
        chk(wr_cnt[1] == 9 && wr_bad == 0, "R4 slow source writes", wr_cnt[1], 9);
    endtask

    task automatic t_bus_zero_core;
        lat = 1; silent_step = -1; err_step = -1;
        do_reset(2'b01, 0, 3);
        wait_end(200);
        chk(active_ctl == 2'b01, "R1 bus controller", active_ctl, 1);
        chk(core_status == 2'b10, "R4 empty core step done", core_status, 2);
        chk(wr_cnt[0] == 0, "R4 empty core step writes nothing", wr_cnt[0], 0);
        chk(wr_cnt[1] == 3 && wr_bad == 0, "R4 hwfw after empty core", wr_cnt[1], 3);
    endtask

    task automatic t_core_error;
        lat = 0; silent_step = -1; err_step = 0; err_addr = 2;
        do_reset(2'b00, 6, 4);
        wait_end(200);
        chk(core_status == 2'b11, "R5 core failed on error", core_status, 3);
        chk(load_status == 2'b00, "R5 hwfw stays idle", load_status, 0);
        chk(wr_cnt[0] == 2 && wr_bad == 0, "R5 words before error", wr_cnt[0], 2);
        req_seen = 0;
        repeat (50) @(negedge clk); #(CLK_P/2);
        chk(core_status == 2'b11, "R7 failure sticky", core_status, 3);
        chk(req_seen == 0, "R7 no retry", req_seen, 0);
        err_step = -1;
        do_reset(2'b00, 6, 4);
        wait_end(200);
        chk(load_status == 2'b10 && wr_cnt[0] == 6, "R7 reset restarts load", load_status, 2);
    endtask

    task automatic t_hwfw_timeout;
        lat = 0; silent_step = 1; err_step = -1;
        do_reset(2'b00, 3, 5);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (load_status == 2'b01) break;
        end
        repeat (1000) @(negedge clk); #1;
        chk(load_status == 2'b01, "R6 still loading before timeout", load_status, 1);
        repeat (40) @(negedge clk); #1;
        chk(load_status == 2'b11, "R6 failed after timeout", load_status, 3);
        chk(core_status == 2'b10, "R6 core stays done", core_status, 2);
        chk(!src_req, "R5 request dropped after failure", src_req, 0);
        silent_step = -1;
    endtask

    task automatic t_reserved_mode;
        lat = 0; silent_step = -1; err_step = -1;
        do_reset(2'b11, 4, 4);
        repeat (20) @(negedge clk); #(CLK_P/2);
        chk(mode_err == 1'b1, "R8 mode error set", mode_err, 1);
        chk(core_status == 2'b00 && load_status == 2'b00, "R8 no step started", core_status, 0);
        chk(req_seen == 0, "R8 no request", req_seen, 0);
        mode_pins = 2'b00;
        repeat (5) @(negedge clk); #1;
        chk(mode_err && core_status == 2'b00, "R8 error holds until reset", mode_err, 1);
    endtask

    task automatic t_runtime_switch;
        lat = 0; silent_step = -1; err_step = -1;
        do_reset(2'b00, 2, 2);
        wait_end(100);
        req_seen = 0;
        mode_pins = 2'b10;
        repeat (2) @(negedge clk); #1;
        chk(active_ctl == 2'b10, "R9 switch to EEPROM after done", active_ctl, 2);
        mode_pins = 2'b11;
        repeat (2) @(negedge clk); #1;
        chk(active_ctl == 2'b10 && !mode_err, "R9 reserved ignored after done", active_ctl, 2);
        mode_pins = 2'b01;
        repeat (2) @(negedge clk); #(CLK_P/2);
        chk(active_ctl == 2'b01, "R9 switch to bus after done", active_ctl, 1);
        chk(req_seen == 0 && load_status == 2'b10, "R9 no reload on switch", req_seen, 0);
    endtask

    task automatic t_switch_during_load;
        lat = 2; silent_step = -1; err_step = -1;
        do_reset(2'b00, 30, 4);
        repeat (10) @(negedge clk);
        mode_pins = 2'b10;
        repeat (5) @(negedge clk); #1;
        chk(active_ctl == 2'b00 && core_status == 2'b01, "R10 change ignored while loading", active_ctl, 0);
        mode_pins = 2'b11;
        repeat (5) @(negedge clk); #1;
        chk(active_ctl == 2'b00 && !mode_err, "R10 reserved ignored while loading", active_ctl, 0);
        mode_pins = 2'b00;
        wait_end(400);
        chk(load_status == 2'b10 && wr_cnt[0] == 30 && wr_bad == 0, "R10 load completes", wr_cnt[0], 30);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_rom_load();
        t_eeprom_slow();
        t_bus_zero_core();
        t_core_error();
        t_hwfw_timeout();
        t_reserved_mode();
        t_runtime_switch();
        t_switch_during_load();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule